// File: doc/BRIEF.md
# GPIO Interrupt Sense and Status Unit

This unit watches the input side of a 32-pin GPIO port and turns pin activity into interrupt requests. Every pin is brought into the clock domain through a small synchronizer. The pin then passes through a detector whose condition comes from its own 4-bit sense field: a rising edge, a falling edge, any change, a high level or a low level. A detected condition sets the pin's pending bit, provided the pin's detection enable is on. Pending bits stay set until software acknowledges them.

Software reads the raw pending bits and also a status view in which each pending bit is gated by the pin's unmask bit. Masking uses separate set and clear strobes, so no read-modify-write is needed. The gated status of the lower half of the pins and of the upper half each drive one registered interrupt line. The usual way to change a sense field is to clear the pin's detection enable, rewrite the field, acknowledge the pin, and then enable it again.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, the detection enable, unmask and pending registers are zero, all sense fields read zero and both interrupt lines are low.
- R2: The sense field of pin n occupies bits 4*(n%8)+3 down to 4*(n%8) of the register at byte offset 0x40+4*(n/8). All four sense registers (0x40 to 0x4C) read back what was last written.
- R3: The sense field's low three bits select the detection mode. Code 0 latches pending on a rising edge of the synchronized pin, code 1 on a falling edge, and code 4 on either edge.
- R4: Code 2 (high level) and code 3 (low level) set pending in every cycle in which the level is present. An acknowledge therefore does not clear the pin while the level persists.
- R5: Bit 3 of a sense field does not change detection. Codes 5, 6 and 7 never set pending.
- R6: The register at 0x14 holds the per-pin detection enable and reads back as written. A pin whose enable bit is 0 never sets its pending bit.
- R7: Writing 1 to a bit at 0x18 unmasks that pin. Writing 1 to a bit at 0x1C masks it. Zero bits leave the mask unchanged, and the unmask register reads back at 0x18.
- R8: Offset 0x20 reads the raw pending bits. Offset 0x24 reads the pending bits ANDed with the unmask register.
- R9: Writing 1 to a bit at 0x28 clears that pin's pending bit. Zero bits leave pending bits unchanged.
- R10: irq_out[0] is high when any gated status bit 0 to 15 is set, and irq_out[1] when any bit 16 to 31 is set. Each line is registered and follows the status one cycle later.
- R11: Read data appears on bus_rdata the cycle after bus_re is sampled. Offsets 0x1C and 0x28 and any unmapped offset read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | N_PINS (32) | Asynchronous GPIO pin levels |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | AW (7) | Byte offset of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data |
| irq_out | output | N_IRQ (2) | Interrupt lines, one per half of the pins |

## Verification
The bench builds the unit with its default parameters: 32 pins, a 2-stage synchronizer, two interrupt lines and four sense registers. At this size all four sense registers are used, and both interrupt halves can be driven, including pin 20 in the upper half. Directed steps place each sense code, including the async flag bit and an invalid code, on neighbouring pins of the first sense register. This shows edge latching, level persistence after an acknowledge, and gating by the enable. Random rounds then rewrite every sense field, enable and mask, toggle sparse sets of pins, and compare raw pending, gated status and both interrupt lines against a bench model.

// File: rtl/gis_pkg.sv
package gis_pkg;
  localparam int OFS_DET_EN   = 'h14;
  localparam int OFS_UNMASK   = 'h18;
  localparam int OFS_MASK     = 'h1C;
  localparam int OFS_RAW      = 'h20;
  localparam int OFS_STATUS   = 'h24;
  localparam int OFS_ACK      = 'h28;
  localparam int OFS_SNS_BASE = 'h40;
  localparam int FIELDS_PER_REG = 8;

  typedef enum logic [2:0] {
    SNS_RISE = 3'd0,
    SNS_FALL = 3'd1,
    SNS_HIGH = 3'd2,
    SNS_LOW  = 3'd3,
    SNS_BOTH = 3'd4
  } sense_e;
endpackage

// File: rtl/gis_sync.sv
module gis_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gis_pin_detect.sv
module gis_pin_detect
  import gis_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl,
  input  logic       enable,
  input  logic [2:0] code,
  input  logic       clr,
  output logic       pend
);
  logic prev_q;
  logic pend_q;
  logic hit;

  always_comb begin
    case (sense_e'(code))
      SNS_RISE: hit = lvl & ~prev_q;
      SNS_FALL: hit = ~lvl & prev_q;
      SNS_HIGH: hit = lvl;
      SNS_LOW:  hit = ~lvl;
      SNS_BOTH: hit = lvl ^ prev_q;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      pend_q <= (pend_q & ~clr) | (hit & enable);
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/gis_regfile.sv
module gis_regfile
  import gis_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int AW     = 7,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [N_PINS-1:0] pend,
  output logic [N_PINS-1:0] det_en,
  output logic [N_PINS-1:0] unmask,
  output logic [N_PINS-1:0] ack,
  output logic [N_PINS*3-1:0] codes
);
  localparam int NREG = (N_PINS + FIELDS_PER_REG - 1) / FIELDS_PER_REG;

  logic [N_PINS-1:0] en_q;
  logic [N_PINS-1:0] unm_q;
  logic [DW-1:0]     sns_q [NREG];
  logic [DW-1:0]     rd_mux;
  logic [DW-1:0]     rdata_q;
  logic [N_PINS-1:0] wbits;

  assign wbits = bus_wdata[N_PINS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      unm_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == AW'(OFS_DET_EN)) en_q  <= wbits;
      if (bus_addr == AW'(OFS_UNMASK)) unm_q <= unm_q | wbits;
      if (bus_addr == AW'(OFS_MASK))   unm_q <= unm_q & ~wbits;
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_sns
    always_ff @(posedge clk) begin
      if (rst) sns_q[k] <= '0;
      else if (bus_we && bus_addr == AW'(OFS_SNS_BASE + 4*k)) sns_q[k] <= bus_wdata;
    end
  end

  for (genvar n = 0; n < N_PINS; n++) begin : g_code
    assign codes[3*n +: 3] = sns_q[n / FIELDS_PER_REG][4*(n % FIELDS_PER_REG) +: 3];
  end

  assign ack = (bus_we && bus_addr == AW'(OFS_ACK)) ? wbits : '0;

  always_comb begin
    rd_mux = '0;
    case (int'(bus_addr))
      OFS_DET_EN: rd_mux = DW'(en_q);
      OFS_UNMASK: rd_mux = DW'(unm_q);
      OFS_RAW:    rd_mux = DW'(pend);
      OFS_STATUS: rd_mux = DW'(pend & unm_q);
      default:    rd_mux = '0;
    endcase
    for (int k = 0; k < NREG; k++) begin
      if (bus_addr == AW'(OFS_SNS_BASE + 4*k)) rd_mux = sns_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_re) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign det_en    = en_q;
  assign unmask    = unm_q;
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
  parameter int N_PINS      = 32,
  parameter int N_IRQ       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 7,
  parameter int DW          = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_in,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [N_IRQ-1:0]  irq_out
);
  localparam int PPI = N_PINS / N_IRQ;

  logic [N_PINS-1:0]   pin_sync;
  logic [N_PINS-1:0]   pend_w;
  logic [N_PINS-1:0]   det_en_w;
  logic [N_PINS-1:0]   unmask_w;
  logic [N_PINS-1:0]   ack_w;
  logic [N_PINS*3-1:0] codes_w;
  logic [N_PINS-1:0]   status_w;
  logic [N_IRQ-1:0]    irq_q;

  gis_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  for (genvar n = 0; n < N_PINS; n++) begin : g_pin
    gis_pin_detect u_det (
      .clk(clk), .rst(rst),
      .lvl(pin_sync[n]),
      .enable(det_en_w[n]),
      .code(codes_w[3*n +: 3]),
      .clr(ack_w[n]),
      .pend(pend_w[n])
    );
  end

  gis_regfile #(.N_PINS(N_PINS), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend(pend_w), .det_en(det_en_w), .unmask(unmask_w),
    .ack(ack_w), .codes(codes_w)
  );

  assign status_w = pend_w & unmask_w;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
    always_ff @(posedge clk) begin
      if (rst) irq_q[g] <= 1'b0;
      else irq_q[g] <= |status_w[g*PPI +: PPI];
    end
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/gis_checker.sv
module gis_checker #(
  parameter int N_PINS = 32,
  parameter int N_IRQ  = 2,
  parameter int AW     = 7,
  parameter int DW     = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_we,
  input logic                bus_re,
  input logic [AW-1:0]       bus_addr,
  input logic [DW-1:0]       bus_wdata,
  input logic [DW-1:0]       bus_rdata,
  input logic [N_IRQ-1:0]    irq_out,
  input logic [N_PINS-1:0]   pend,
  input logic [N_PINS-1:0]   unmask,
  input logic [N_PINS-1:0]   det_en,
  input logic [N_PINS*3-1:0] codes
);
  localparam int PPI = N_PINS / N_IRQ;
  localparam int NREG = (N_PINS + 7) / 8;

  logic [N_PINS-1:0] bad_code;
  logic [N_PINS-1:0] gated;
  logic              quiet_addr;

  always_comb begin
    for (int n = 0; n < N_PINS; n++) bad_code[n] = (codes[3*n +: 3] > 3'd4);
  end

  assign gated = pend & unmask;

  always_comb begin
    quiet_addr = !(bus_addr == AW'('h14) || bus_addr == AW'('h18) ||
                   bus_addr == AW'('h20) || bus_addr == AW'('h24));
    for (int k = 0; k < NREG; k++)
      if (bus_addr == AW'('h40 + 4*k)) quiet_addr = 1'b0;
  end

  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq_chk
    AST_IRQ_FOLLOWS_STATUS: assert property (@(posedge clk) disable iff (rst)
      irq_out[g] == $past(|gated[g*PPI +: PPI])); // R10
  end

  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend)) & ~$past(det_en)) == '0); // R6

  AST_BAD_CODE_NO_SET: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend)) & $past(bad_code)) == '0); // R5

  AST_UNMASK_SET: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'('h18)) |=>
      ((unmask & N_PINS'($past(bus_wdata))) == N_PINS'($past(bus_wdata)))); // R7

  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'('h1C)) |=>
      ((unmask & N_PINS'($past(bus_wdata))) == '0)); // R7

  AST_QUIET_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_re && quiet_addr) |=> (bus_rdata == '0)); // R11
endmodule

bind gpio_irq_sense gis_checker #(
  .N_PINS(N_PINS), .N_IRQ(N_IRQ), .AW(AW), .DW(DW)
) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_out(irq_out), .pend(pend_w), .unmask(unmask_w),
  .det_en(det_en_w), .codes(codes_w)
);

// File: tb/test_gpio_irq_sense.sv
`timescale 1ns/1ps
module test_gpio_irq_sense;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_in = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_out;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] m_en, m_unm, m_pend, pins;
  logic [3:0]  m_code [32];

  always #2.5 clk = ~clk;

  gpio_irq_sense i_gpio_irq_sense (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  function automatic logic lvl_hit(logic [3:0] c, logic p);
    case (c[2:0])
      3'd2: return p;
      3'd3: return !p;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic edge_hit(logic [3:0] c, logic o, logic n);
    case (c[2:0])
      3'd0: return !o && n;
      3'd1: return o && !n;
      3'd4: return o != n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] lvl_vec(logic [31:0] p);
    logic [31:0] v;
    for (int i = 0; i < 32; i++) v[i] = m_en[i] & lvl_hit(m_code[i], p[i]);
    return v;
  endfunction

  task automatic move_pins(input logic [31:0] nv);
    pin_in = nv;
    settle();
    for (int i = 0; i < 32; i++)
      if (m_en[i] && (edge_hit(m_code[i], pins[i], nv[i]) || lvl_hit(m_code[i], nv[i])))
        m_pend[i] = 1'b1;
    pins = nv;
  endtask

  task automatic random_config();
    logic [31:0] w;
    wr(7'h14, 32'h0);
    m_en = '0;
    for (int k = 0; k < 4; k++) begin
      w = $urandom;
      wr(7'(8'h40 + 4*k), w);
      for (int f = 0; f < 8; f++) m_code[8*k+f] = w[4*f +: 4];
    end
    wr(7'h28, 32'hFFFF_FFFF);
    m_pend = '0;
    wr(7'h1C, 32'hFFFF_FFFF);
    m_unm = $urandom;
    wr(7'h18, m_unm);
    m_en = $urandom | $urandom;
    wr(7'h14, m_en);
    settle();
    m_pend = lvl_vec(pins);
  endtask

  logic [31:0] r;
  logic [31:0] ackv;
  int seed;

  initial begin
    seed = $urandom(32'h5EED_0042);
    pins = '0;
    m_en = '0; m_unm = '0; m_pend = '0;
    for (int i = 0; i < 32; i++) m_code[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(7'h14, r); check("R1 enable", r, 32'h0);
    rd(7'h18, r); check("R1 unmask", r, 32'h0);
    rd(7'h20, r); check("R1 raw", r, 32'h0);
    rd(7'h24, r); check("R1 status", r, 32'h0);
    for (int k = 0; k < 4; k++) begin
      rd(7'(8'h40 + 4*k), r); check("R1 sense", r, 32'h0);
    end
    check("R1 irq", 32'(irq_out), 32'h0);

    // R2 sense register readback
    wr(7'h44, 32'h4321_0A98); rd(7'h44, r); check("R2 sense 0x44", r, 32'h4321_0A98);
    wr(7'h4C, 32'h89AB_CDEF); rd(7'h4C, r); check("R2 sense 0x4C", r, 32'h89AB_CDEF);
    wr(7'h44, 32'h0); wr(7'h4C, 32'h0);

    // R11 quiet offsets
    rd(7'h28, r); check("R11 ack reads zero", r, 32'h0);
    rd(7'h30, r); check("R11 unmapped", r, 32'h0);

    // directed: pin0 rise, pin1 fall, pin2 both, pin3 high, pin4 low,
    // pin5 high+async flag, pin6 invalid code 5, pin7 rise but disabled
    wr(7'h40, 32'h05A3_2410);
    wr(7'h28, 32'hFF);
    wr(7'h14, 32'h7F);
    rd(7'h14, r); check("R6 enable readback", r, 32'h7F);
    settle();
    rd(7'h20, r); check("R4 low level pends at enable", r, 32'h10);

    pin_in = 32'hFF; settle();
    rd(7'h20, r);
    check("R3 rising pin0", 32'(r[0]), 32'h1);
    check("R3 falling pin1 no hit", 32'(r[1]), 32'h0);
    check("R3 both pin2", 32'(r[2]), 32'h1);
    check("R4 high pin3", 32'(r[3]), 32'h1);
    check("R5 async flag pin5", 32'(r[5]), 32'h1);
    check("R5 invalid code pin6", 32'(r[6]), 32'h0);
    check("R6 disabled pin7", 32'(r[7]), 32'h0);

    wr(7'h28, 32'hFF); rd(7'h20, r);
    check("R4 level persists after ack", r, 32'h28);
    wr(7'h28, 32'h00); rd(7'h20, r);
    check("R9 zero ack bits", r, 32'h28);

    pin_in = 32'h00; settle();
    rd(7'h20, r); check("R3 falling and both", r, 32'h3E);

    wr(7'h18, 32'h3C); rd(7'h24, r); check("R8 status gated", r, 32'h3C);
    check("R10 low line", 32'(irq_out), 32'h1);
    wr(7'h1C, 32'h34); rd(7'h18, r); check("R7 mask clear", r, 32'h08);
    wr(7'h18, 32'h0); rd(7'h18, r); check("R7 zero bits", r, 32'h08);
    rd(7'h24, r); check("R8 status after mask", r, 32'h08);
    wr(7'h28, 32'h02); rd(7'h20, r); check("R9 single ack", r, 32'h3C);
    wr(7'h1C, 32'hFFFF_FFFF); @(negedge clk);
    check("R10 all masked", 32'(irq_out), 32'h0);

    wr(7'h14, 32'h0010_007F);
    wr(7'h18, 32'h0010_0000);
    pin_in = 32'h0010_0000; settle();
    rd(7'h20, r); check("R3 pin20 rising", 32'(r[20]), 32'h1);
    check("R10 high line", 32'(irq_out), 32'h2);
    pins = pin_in;

    // random rounds against the bench model
    for (int round = 0; round < 4; round++) begin
      random_config();
      rd(7'h18, r); check("R7 unmask random", r, m_unm);
      for (int step = 0; step < 30; step++) begin
        move_pins(pins ^ ($urandom & $urandom));
        if ($urandom % 3 == 0) begin
          ackv = $urandom;
          wr(7'h28, ackv);
          m_pend = (m_pend & ~ackv) | lvl_vec(pins);
        end
        rd(7'h20, r); check("R8 raw random", r, m_pend);
        rd(7'h24, r); check("R8 status random", r, m_pend & m_unm);
        check("R10 irq random", 32'(irq_out),
              {30'h0, |(m_pend[31:16] & m_unm[31:16]), |(m_pend[15:0] & m_unm[15:0])});
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule